// File: doc/BRIEF.md
# External Pin Interrupt Controller

This block watches one external input pin and turns activity on it into an interrupt request for a small 8-bit processor core. A 2-bit sense-control input selects what counts as activity: a low level, any change, a falling edge or a rising edge. In the three edge modes a detected event latches a pending flag. In low-level mode no flag is kept and the request follows the pin directly. The pin is sampled whatever its output driver is doing, so software can raise an interrupt by driving the pin itself.

Software reaches two one-bit registers over a simple register bus with an address, write data, a write strobe and read data: an enable mask and the pending flag. The request to the core is the AND of the mask, a global interrupt enable and the trigger condition, and it is registered. The pending flag is cleared either when software writes a one to it or when the core acknowledges that it has entered the interrupt vector.

The pin passes through a synchronizer of configurable depth (two stages by default). Edges are found by comparing the synchronized value with its value one cycle earlier, so each pin transition gives exactly one event.

Top module: `ext_irq_unit`

## Requirements
- R1: After a synchronous reset the mask and flag bits are 0, the read data is 0 and `irq_req_o` is 0.
- R2: The mask register is at address 0x13. Bit 0 of the write data is stored on a write strobe and reads back in bit 0 one clock after the address is presented.
- R3: Bits 7:1 of both registers always read 0, and writing ones to them changes nothing.
- R4: With sense 2'b11, a 0-to-1 change of the pin sets the flag (address 0x14, bit 0) at the third rising clock edge after the change. A 1-to-0 change and a pin that stays high do not set it.
- R5: With sense 2'b10, a 1-to-0 change of the pin sets the flag. A 0-to-1 change does not.
- R6: With sense 2'b01, both directions of pin change set the flag.
- R7: In an edge mode `irq_req_o` is 1 exactly when, at the previous clock edge, the flag, the mask and `gie_i` were all 1. It rises one edge after the flag is set, and clearing the mask or `gie_i` drops it.
- R8: With sense 2'b00, the flag reads 0 at all times. `irq_req_o` is 1 from the third edge after the pin goes low until the third edge after it goes high, while the mask and `gie_i` are 1.
- R9: A write to address 0x14 with bit 0 set clears the flag. A write with bit 0 clear leaves the flag unchanged.
- R10: `irq_ack_i` clears a set flag in an edge mode. In low-level mode it has no effect on the request.
- R11: When a new pin event and a clear (by write or by acknowledge) reach the flag at the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_i | input | 1 | External pin level, asynchronous |
| sense_i | input | 2 | Trigger select: 00 low level, 01 any change, 10 falling, 11 rising |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_we_i | input | 1 | Write strobe |
| bus_rdata_o | output | 8 | Registered read data for the presented address |
| gie_i | input | 1 | Global interrupt enable from the core |
| irq_ack_i | input | 1 | Core has taken the vector |
| irq_req_o | output | 1 | Registered interrupt request to the core |

## Verification
The pin is driven through rising, falling and double transitions under each of the four sense settings. A transition of the wrong direction must leave the flag clear, which separates the rising, falling and any-change decoders. A pin held steady after an edge checks that one transition sets the flag only once. The low-level runs pair a low pin with acknowledges and flag reads to show the request follows the pin and not a latch. Clears are also timed to land at the same edge as a new event, which shows which one wins.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int   STAGES     = 2,
  parameter logic IDLE_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= IDLE_LEVEL;
        else     chain_q[0] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain_q[i] <= IDLE_LEVEL;
        else     chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/eirq_detect.sv
module eirq_detect
  import ext_irq_pkg::*;
#(
  parameter logic IDLE_LEVEL = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       level_i,
  input  logic [1:0] sense_i,
  output logic       set_evt_o,
  output logic       level_act_o,
  output logic       level_mode_o
);

  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= IDLE_LEVEL;
    else     prev_q <= level_i;
  end

  assign rise = level_i & ~prev_q;
  assign fall = ~level_i & prev_q;

  always_comb begin
    set_evt_o = 1'b0;
    case (sense_e'(sense_i))
      SENSE_ANY:  set_evt_o = rise | fall;
      SENSE_FALL: set_evt_o = fall;
      SENSE_RISE: set_evt_o = rise;
      default:    set_evt_o = 1'b0;
    endcase
  end

  assign level_mode_o = (sense_e'(sense_i) == SENSE_LOW);
  assign level_act_o  = level_mode_o & ~level_i;

endmodule

// File: rtl/eirq_regs.sv
module eirq_regs #(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 8,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h13,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              set_evt_i,
  input  logic              ack_i,
  input  logic              level_mode_i,
  output logic              mask_o,
  output logic              flag_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic              mask_q, flag_q;
  logic              hit_mask, hit_flag;
  logic              clr_write, clr_ack;
  logic [DATA_W-1:0] rd_next;

  assign hit_mask  = (addr_i == MASK_ADDR);
  assign hit_flag  = (addr_i == FLAG_ADDR);
  assign clr_write = we_i & hit_flag & wdata_i[0];
  assign clr_ack   = ack_i & flag_q;

  always_ff @(posedge clk) begin
    if (rst)                     mask_q <= 1'b0;
    else if (we_i && hit_mask)   mask_q <= wdata_i[0];
  end

  // A new event takes priority over either clear source.
  always_ff @(posedge clk) begin
    if (rst)                         flag_q <= 1'b0;
    else if (level_mode_i)           flag_q <= 1'b0;
    else if (set_evt_i)              flag_q <= 1'b1;
    else if (clr_write || clr_ack)   flag_q <= 1'b0;
  end

  always_comb begin
    rd_next = '0;
    if (hit_mask)      rd_next[0] = mask_q;
    else if (hit_flag) rd_next[0] = flag_q & ~level_mode_i;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_next;
  end

  assign mask_o = mask_q;
  assign flag_o = flag_q;

endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit #(
  parameter int                SYNC_STAGES = 2,
  parameter logic              IDLE_LEVEL  = 1'b0,
  parameter int                ADDR_W      = 8,
  parameter int                DATA_W      = 8,
  parameter logic [ADDR_W-1:0] MASK_ADDR   = 8'h13,
  parameter logic [ADDR_W-1:0] FLAG_ADDR   = 8'h14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_i,
  input  logic [1:0]        sense_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              bus_we_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              gie_i,
  input  logic              irq_ack_i,
  output logic              irq_req_o
);

  logic pin_sync;
  logic set_evt, level_act, level_mode;
  logic mask_q, flag_q;
  logic req_q;

  eirq_sync #(.STAGES(SYNC_STAGES), .IDLE_LEVEL(IDLE_LEVEL)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (pin_i),
    .sync_o  (pin_sync)
  );

  eirq_detect #(.IDLE_LEVEL(IDLE_LEVEL)) u_det (
    .clk          (clk),
    .rst          (rst),
    .level_i      (pin_sync),
    .sense_i      (sense_i),
    .set_evt_o    (set_evt),
    .level_act_o  (level_act),
    .level_mode_o (level_mode)
  );

  eirq_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .MASK_ADDR(MASK_ADDR), .FLAG_ADDR(FLAG_ADDR)
  ) u_regs (
    .clk          (clk),
    .rst          (rst),
    .addr_i       (bus_addr_i),
    .wdata_i      (bus_wdata_i),
    .we_i         (bus_we_i),
    .set_evt_i    (set_evt),
    .ack_i        (irq_ack_i),
    .level_mode_i (level_mode),
    .mask_o       (mask_q),
    .flag_o       (flag_q),
    .rdata_o      (bus_rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= mask_q & gie_i & (level_mode ? level_act : flag_q);
  end

  assign irq_req_o = req_q;

endmodule

// File: rtl/ext_irq_chk.sv
module ext_irq_chk #(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h14
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        sense_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic              bus_we_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              gie_i,
  input logic              irq_ack_i,
  input logic              irq_req_o,
  input logic              mask_q,
  input logic              flag_q,
  input logic              set_evt
);

  logic wr_clr;
  assign wr_clr = bus_we_i && (bus_addr_i == FLAG_ADDR) && bus_wdata_i[0];

  AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_rdata_o[DATA_W-1:1] == '0); // R3

  AST_REQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_req_o |-> ($past(gie_i) && $past(mask_q))); // R7

  AST_LEVEL_FLAG_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sense_i == 2'b00 && bus_addr_i == FLAG_ADDR) |=> (bus_rdata_o[0] == 1'b0)); // R8

  AST_WRITE_ONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_clr && !set_evt) |=> !flag_q); // R9

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !wr_clr && !irq_ack_i && sense_i != 2'b00) |=> flag_q); // R9

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (irq_ack_i && flag_q && !set_evt) |=> !flag_q); // R10

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> flag_q); // R11

endmodule

bind ext_irq_unit ext_irq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLAG_ADDR(FLAG_ADDR)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sense_i     (sense_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_we_i    (bus_we_i),
  .bus_rdata_o (bus_rdata_o),
  .gie_i       (gie_i),
  .irq_ack_i   (irq_ack_i),
  .irq_req_o   (irq_req_o),
  .mask_q      (mask_q),
  .flag_q      (flag_q),
  .set_evt     (set_evt)
);

// File: tb/sim_ext_irq_unit.sv
`timescale 1ns/1ps
module sim_ext_irq_unit;

  localparam logic [7:0] A_MASK = 8'h13;
  localparam logic [7:0] A_FLAG = 8'h14;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin = 1'b0;
  logic [1:0] sense = 2'b11;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic       we = 1'b0;
  logic [7:0] rdata;
  logic       gie = 1'b0;
  logic       ack = 1'b0;
  logic       req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ext_irq_unit u0 (
    .clk(clk), .rst(rst), .pin_i(pin), .sense_i(sense),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_we_i(we),
    .bus_rdata_o(rdata), .gie_i(gie), .irq_ack_i(ack), .irq_req_o(req)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    step(1);
    we = 1'b0; wdata = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a;
    step(1);
    d = rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 req after reset", {7'd0, req}, 8'h00);
    chk("R1 rdata after reset", rdata, 8'h00);
    rd(A_MASK, v); chk("R1 mask after reset", v, 8'h00);
    rd(A_FLAG, v); chk("R1 flag after reset", v, 8'h00);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    wr(A_MASK, 8'hFF); rd(A_MASK, v); chk("R2 mask write ff", v, 8'h01);
    wr(A_MASK, 8'hFE); rd(A_MASK, v); chk("R3 mask write fe", v, 8'h00);
    wr(A_MASK, 8'h01); rd(A_MASK, v); chk("R2 mask write 01", v, 8'h01);
    wr(A_FLAG, 8'hFE); rd(A_FLAG, v); chk("R3 flag reserved", v, 8'h00);
  endtask

  task automatic t_rise;
    sense = 2'b11; gie = 1'b1; addr = A_FLAG;
    pin = 1'b1;
    step(3); chk("R7 req not before flag", {7'd0, req}, 8'h00);
    step(1);
    chk("R4 rising sets flag", rdata, 8'h01);
    chk("R7 req follows flag", {7'd0, req}, 8'h01);
    step(6); chk("R4 flag held", rdata, 8'h01);
    wr(A_FLAG, 8'h01); step(1);
    chk("R9 write one clears", rdata, 8'h00);
    chk("R7 req drops after clear", {7'd0, req}, 8'h00);
    step(5); chk("R4 steady high no retrigger", rdata, 8'h00);
    pin = 1'b0;
    step(6); chk("R4 falling ignored", rdata, 8'h00);
  endtask

  task automatic t_fall;
    sense = 2'b10; addr = A_FLAG;
    pin = 1'b1;
    step(6); chk("R5 rising ignored", rdata, 8'h00);
    pin = 1'b0;
    step(4); chk("R5 falling sets flag", rdata, 8'h01);
    wr(A_FLAG, 8'h01); step(1);
    chk("R9 clear after fall", rdata, 8'h00);
  endtask

  task automatic t_any;
    sense = 2'b01; addr = A_FLAG;
    pin = 1'b1;
    step(4); chk("R6 rise sets flag", rdata, 8'h01);
    wr(A_FLAG, 8'h01); step(1);
    chk("R6 cleared", rdata, 8'h00);
    pin = 1'b0;
    step(4); chk("R6 fall sets flag", rdata, 8'h01);
    wr(A_FLAG, 8'h01); step(1);
  endtask

  task automatic t_gate;
    sense = 2'b11; gie = 1'b0; addr = A_FLAG;
    pin = 1'b1;
    step(4);
    chk("R4 flag set with gie low", rdata, 8'h01);
    chk("R7 gie low blocks req", {7'd0, req}, 8'h00);
    gie = 1'b1;
    step(1); chk("R7 gie high gives req", {7'd0, req}, 8'h01);
    wr(A_MASK, 8'h00); addr = A_FLAG;
    step(1); chk("R7 mask low blocks req", {7'd0, req}, 8'h00);
    wr(A_FLAG, 8'hFE); step(1);
    chk("R9 write zero keeps flag", rdata, 8'h01);
    wr(A_MASK, 8'h01); addr = A_FLAG;
    step(1); chk("R7 mask restored req", {7'd0, req}, 8'h01);
    ack = 1'b1; step(1); ack = 1'b0;
    step(1);
    chk("R10 ack clears flag", rdata, 8'h00);
    chk("R10 req drops after ack", {7'd0, req}, 8'h00);
  endtask

  task automatic t_level;
    sense = 2'b00; gie = 1'b1; addr = A_FLAG;
    pin = 1'b0;
    step(2); chk("R8 req not yet", {7'd0, req}, 8'h00);
    step(1); chk("R8 low pin gives req", {7'd0, req}, 8'h01);
    chk("R8 flag reads zero", rdata, 8'h00);
    ack = 1'b1; step(1); ack = 1'b0;
    step(2); chk("R10 ack ignored in level mode", {7'd0, req}, 8'h01);
    gie = 1'b0; step(1);
    chk("R7 gie low blocks level req", {7'd0, req}, 8'h00);
    gie = 1'b1; step(1);
    pin = 1'b1;
    step(3); chk("R8 high pin drops req", {7'd0, req}, 8'h00);
    chk("R8 flag still zero", rdata, 8'h00);
  endtask

  task automatic t_setwin;
    sense = 2'b11; addr = A_FLAG;
    pin = 1'b0; step(4);
    chk("R11 flag clear before", rdata, 8'h00);
    pin = 1'b1; step(2);
    we = 1'b1; wdata = 8'h01;
    step(1);
    we = 1'b0; wdata = 8'h00;
    step(1); chk("R11 event beats write clear", rdata, 8'h01);
    wr(A_FLAG, 8'h01); addr = A_FLAG;
    pin = 1'b0; step(4);
    chk("R11 cleared between", rdata, 8'h00);
    pin = 1'b1; step(2);
    ack = 1'b1; step(1); ack = 1'b0;
    step(1); chk("R11 event beats ack", rdata, 8'h01);
    wr(A_FLAG, 8'h01);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_regs();
    t_rise();
    t_fall();
    t_any();
    t_gate();
    t_level();
    t_setwin();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule